// File: doc/BRIEF.md
# Three-Phase Gate Command Interlock

This block sits between a PWM generator and the gate drivers of a three-phase inverter bridge. Each phase has a high-side command and a low-side command. The block turns each pair into two gate enables and applies three protections. The first is a glitch filter on every command line. The second is a deadtime between one switch of a phase going off and either switch of that phase coming on. The third is a lockout, so that the two switches of a phase can never conduct together. A fault manager drives a global kill line. That line forces all six gates off on the next clock edge, and it does not pass through the filters or the deadtime logic.

Low-side commands are always active-low. A build-time parameter sets the high-side commands to active-low or active-high. All phases come from one generate loop and share one register path, so every phase sees the same delay from command edge to gate edge. The filter length and the deadtime are set in clock cycles. For example, 20 and 25 cycles at 100 MHz give 200 ns and 250 ns.

Top module: `gate_guard3`

## Requirements
- R1: During reset all gate outputs are 0. After reset is released, no gate turns on before DT_CYC clock edges have passed, counted from the first edge after release.
- R2: A low-side command requests its gate when the pin is 0 and releases it when the pin is 1.
- R3: With HI_ACT_LOW=1 a high-side command requests its gate when the pin is 0. With HI_ACT_LOW=0 it requests when the pin is 1.
- R4: The high-side and low-side gates of one phase are never 1 in the same cycle.
- R5: A command level reaches the interlock only after FLT_CYC consecutive clock samples of that level. A pulse of FLT_CYC-1 samples has no effect on the gates.
- R6: When the deadtime has already expired, a gate follows an accepted command change on clock edge FLT_CYC+2 after the input edge. Turn-on and turn-off take the same number of edges, and all phases take the same number of edges.
- R7: After both gates of a phase have gone off, neither gate of that phase turns on until DT_CYC edges have passed. A pending request turns its gate on exactly on edge DT_CYC after the turn-off edge.
- R8: While both filtered requests of a phase are active, both gates of that phase are 0 from the next edge on. The deadtime restarts when the overlap ends.
- R9: A 1 on kill forces all six gates to 0 on the next edge, even for a one-cycle pulse. The deadtime counts from the first edge on which kill is 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | NUM_PH | High-side commands; polarity set by HI_ACT_LOW |
| lo_cmd_n | input | NUM_PH | Low-side commands, active-low |
| kill | input | 1 | Global shutdown, active-high |
| hi_gate | output | NUM_PH | High-side gate enables, registered |
| lo_gate | output | NUM_PH | Low-side gate enables, registered |

## Verification
Each command input is sampled by a single register with no synchronizer, so the assertions assume every command and the kill line are synchronous to clk. The bench changes all inputs only on the falling edge, which satisfies this. The deadtime assertion assumes reset has held the outputs off, so that the off-run counter starts from a known idle state. The bench applies reset before any command is driven. The stimulus is an exhaustive sweep of every pair of three-phase command patterns, plus directed overlap, glitch and kill cases. Each step waits long enough for the filter and the deadtime to settle before the next pattern is applied.

// File: rtl/gg_pkg.sv
package gg_pkg;
  // Converts a pin level into an active-high request.
  function automatic logic req_level(logic pin, bit act_low);
    return act_low ? ~pin : pin;
  endfunction
endpackage

// File: rtl/gg_filter.sv
module gg_filter #(
  parameter int FLT_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FLT_CYC + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(FLT_CYC - 1);

  logic          samp_q;
  logic          out_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      out_q  <= 1'b0;
      run_q  <= '0;
    end else begin
      samp_q <= din;
      if (samp_q == out_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        out_q <= samp_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign dout = out_q;

  // R5: the hold counter never passes its limit
  a_r5_run_bound: assert property (@(posedge clk) disable iff (rst)
    run_q < CW'(FLT_CYC));

  // R5: the output moves only after a full run of differing samples
  a_r5_hold_before_change: assert property (@(posedge clk) disable iff (rst)
    (out_q != $past(out_q)) |-> ($past(run_q) == RUN_LAST));
endmodule

// File: rtl/gg_phase_lock.sv
module gg_phase_lock #(
  parameter int DT_CYC = 25  // at least 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic rq_h,
  input  logic rq_l,
  output logic h_on,
  output logic l_on
);
  localparam int CW = (DT_CYC < 2) ? 1 : $clog2(DT_CYC);
  localparam int OW = $clog2(DT_CYC + 1);
  localparam logic [CW-1:0] DT_LAST = CW'(DT_CYC - 1);

  logic          h_q, l_q;
  logic [CW-1:0] dt_q;
  logic          ready, overlap, only_h, only_l;
  logic          h_d, l_d;

  assign ready   = (dt_q == DT_LAST);
  assign overlap = rq_h & rq_l;
  assign only_h  = rq_h & ~rq_l;
  assign only_l  = rq_l & ~rq_h;

  always_comb begin
    if (kill) begin
      h_d = 1'b0;
      l_d = 1'b0;
    end else begin
      h_d = h_q ? only_h : (only_h & ~l_q & ready);
      l_d = l_q ? only_l : (only_l & ~h_q & ready);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q  <= 1'b0;
      l_q  <= 1'b0;
      dt_q <= '0;
    end else begin
      h_q <= h_d;
      l_q <= l_d;
      if (h_q | l_q | kill | overlap) dt_q <= '0;
      else if (!ready)                dt_q <= dt_q + 1'b1;
    end
  end

  assign h_on = h_q;
  assign l_on = l_q;

  // Independent count of cycles with both gates off, for the deadtime check
  logic [OW-1:0] off_run_q;
  always_ff @(posedge clk) begin
    if (rst)                    off_run_q <= '0;
    else if (h_q | l_q)         off_run_q <= '0;
    else if (off_run_q != OW'(DT_CYC)) off_run_q <= off_run_q + 1'b1;
  end

  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(h_on && l_on));

  a_r7_deadtime_h: assert property (@(posedge clk) disable iff (rst)
    $rose(h_on) |-> (off_run_q >= OW'(DT_CYC)));

  a_r7_deadtime_l: assert property (@(posedge clk) disable iff (rst)
    $rose(l_on) |-> (off_run_q >= OW'(DT_CYC)));

  a_r8_overlap_off: assert property (@(posedge clk) disable iff (rst)
    (rq_h && rq_l) |=> (!h_on && !l_on));

  a_r9_kill_off: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!h_on && !l_on));
endmodule

// File: rtl/gate_guard3.sv
module gate_guard3 #(
  parameter int NUM_PH     = 3,
  parameter int DT_CYC     = 25,
  parameter int FLT_CYC    = 20,
  parameter bit HI_ACT_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PH-1:0] hi_cmd,
  input  logic [NUM_PH-1:0] lo_cmd_n,
  input  logic              kill,
  output logic [NUM_PH-1:0] hi_gate,
  output logic [NUM_PH-1:0] lo_gate
);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic req_h_raw, req_l_raw, req_h, req_l;

    assign req_h_raw = gg_pkg::req_level(hi_cmd[p], HI_ACT_LOW);
    assign req_l_raw = gg_pkg::req_level(lo_cmd_n[p], 1'b1);

    gg_filter #(.FLT_CYC(FLT_CYC)) u_flt_h (
      .clk(clk), .rst(rst), .din(req_h_raw), .dout(req_h));

    gg_filter #(.FLT_CYC(FLT_CYC)) u_flt_l (
      .clk(clk), .rst(rst), .din(req_l_raw), .dout(req_l));

    gg_phase_lock #(.DT_CYC(DT_CYC)) u_lock (
      .clk(clk), .rst(rst), .kill(kill),
      .rq_h(req_h), .rq_l(req_l),
      .h_on(hi_gate[p]), .l_on(lo_gate[p]));
  end
endmodule

// File: tb/gate_guard3_tb_top.sv
module gate_guard3_tb_top;
  localparam int DT  = 8;
  localparam int FLT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hi  = 3'b001;
  logic [2:0] lo_n = 3'b111;
  logic       kill = 1'b0;
  logic [2:0] hg, lg, hg_i, lg_i;
  logic [2:0] hi_n;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  assign hi_n = ~hi;

  always #5 clk = ~clk;

  gate_guard3 #(.NUM_PH(3), .DT_CYC(DT), .FLT_CYC(FLT), .HI_ACT_LOW(1'b0)) dut_i (
    .clk(clk), .rst(rst), .hi_cmd(hi), .lo_cmd_n(lo_n), .kill(kill),
    .hi_gate(hg), .lo_gate(lg));

  gate_guard3 #(.NUM_PH(3), .DT_CYC(DT), .FLT_CYC(FLT), .HI_ACT_LOW(1'b1)) dut_inv_i (
    .clk(clk), .rst(rst), .hi_cmd(hi_n), .lo_cmd_n(lo_n), .kill(kill),
    .hi_gate(hg_i), .lo_gate(lg_i));

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    step(5);
    chk("R1 reset hi", hg, 3'b000);
    chk("R1 reset lo", lg, 3'b000);
    rst = 1'b0;
    step(7);
    chk("R1 no turn-on before deadtime", hg, 3'b000);
    step(1);
    chk("R1 first turn-on", hg, 3'b001);

    // R6: turn-off latency
    hi[0] = 1'b0;
    step(4);
    chk("R6 turn-off not early", hg, 3'b001);
    step(1);
    chk("R6 turn-off edge", hg, 3'b000);

    // R2: low-side active-low, R6 turn-on latency
    step(20);
    lo_n[0] = 1'b0;
    step(4);
    chk("R2 lo not early", lg, 3'b000);
    step(1);
    chk("R2 lo on", lg, 3'b001);

    // R7: complementary switch
    hi[0] = 1'b1; lo_n[0] = 1'b1;
    step(5);
    chk("R7 lo off", lg, 3'b000);
    chk("R7 hi waits", hg, 3'b000);
    step(7);
    chk("R7 hi still off", hg, 3'b000);
    step(1);
    chk("R7 hi on after deadtime", hg, 3'b001);

    // R5: short glitch rejected
    hi[0] = 1'b0;
    step(2);
    hi[0] = 1'b1;
    step(3);
    chk("R5 glitch rejected", hg, 3'b001);
    step(12);
    chk("R5 glitch rejected late", hg, 3'b001);
    chk("R5 lo untouched", lg, 3'b000);

    // R5/R7: pulse of full filter length accepted, same-side deadtime
    hi[0] = 1'b0;
    step(3);
    hi[0] = 1'b1;
    step(2);
    chk("R5 full pulse passes", hg, 3'b000);
    step(7);
    chk("R7 same-side deadtime", hg, 3'b000);
    step(1);
    chk("R7 same-side reopen", hg, 3'b001);

    // R8: overlap
    lo_n[0] = 1'b0;
    step(4);
    chk("R8 before overlap seen", hg, 3'b001);
    step(1);
    chk("R8 overlap hi off", hg, 3'b000);
    step(10);
    chk("R8 overlap hi held", hg, 3'b000);
    chk("R8 overlap lo held", lg, 3'b000);
    lo_n[0] = 1'b1;
    step(11);
    chk("R8 deadtime after overlap", hg, 3'b000);
    step(1);
    chk("R8 hi after overlap", hg, 3'b001);

    // R9: kill
    kill = 1'b1;
    step(1);
    chk("R9 kill hi", hg, 3'b000);
    chk("R9 kill lo", lg, 3'b000);
    step(5);
    chk("R9 kill held", hg, 3'b000);
    kill = 1'b0;
    step(7);
    chk("R9 deadtime after kill", hg, 3'b000);
    step(1);
    chk("R9 resume after kill", hg, 3'b001);
    kill = 1'b1;
    step(1);
    chk("R9 one-cycle kill", hg, 3'b000);
    kill = 1'b0;
    step(7);
    chk("R9 pulse deadtime", hg, 3'b000);
    step(1);
    chk("R9 pulse resume", hg, 3'b001);

    // R3/R6/R7: every transition between three-phase patterns
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        logic [2:0] pa, pb, ch;
        pa = 3'(a); pb = 3'(b); ch = pa ^ pb;
        hi = pa; lo_n = pa;
        step(25);
        chk("R6 settle hi", hg, pa);
        chk("R6 settle lo", lg, ~pa);
        hi = pb; lo_n = pb;
        step(4);
        chk("R6 hold before edge", hg, pa);
        step(1);
        chk("R6 matched off hi", hg, pa & ~ch);
        chk("R6 matched off lo", lg, ~pa & ~ch);
        step(7);
        chk("R7 gap hi", hg, pa & ~ch);
        chk("R7 gap lo", lg, ~pa & ~ch);
        step(1);
        chk("R7 new hi", hg, pb);
        chk("R7 new lo", lg, ~pb);
        chk("R3 inverted hi", hg_i, pb);
        chk("R3 inverted lo", lg_i, ~pb);
      end
    end
    finish_run();
  end
endmodule